// File: doc/BRIEF.md
# Serial Audio Output Transmitter

This block serializes a left/right pair of 24-bit two's-complement audio samples onto one data line. The bit clock and word-select clock are produced elsewhere and arrive as plain inputs. The block runs on a faster system clock and watches the bit clock for falling edges. On each falling edge it moves the serial output to the next bit position. On the same edge it checks whether the word clock has changed, which marks the start of a new half-frame.

A single format input selects one of two framings. With the format input low, framing is MSB-justified: word clock high carries the left channel and the MSB occupies the first bit period of the half-frame. With the format input high, framing is I2S-style: word clock low carries the left channel and the MSB is delayed by one bit period. The block accepts half-frames of 24 or more bit periods, which carry all 24 bits. It also accepts half-frames of exactly 16 bit periods, and then sends only the upper 16 bits of each sample. A sample pair is written through a parallel port with a load strobe. The pair is taken into use at the start of the next left half-frame, so both channels of a frame belong to the same sample instant. A power-down input silences the output and resets the framing logic.

The framing controller has four states. OFF holds while power-down is asserted. It moves to SEEK once power-down is released, and reset also starts in SEEK. SEEK stays silent until a word-clock edge opens a left half-frame, and then moves to LEFT. Every later word-clock edge moves to LEFT or RIGHT according to the level the word clock now has.

Top module: `serial_audio_tx`

## Requirements
- R1: With fmt_i = 0, word clock level 1 marks the left half-frame, level 0 the right, and the sample MSB is driven in bit slot 0. Slot 0 is the bit period that starts at the falling edge where the word clock changed.
- R2: With fmt_i = 1, word clock level 0 marks the left half-frame, level 1 the right, and the sample MSB is driven in bit slot 1.
- R3: With half-frames of 24 or more slots, all 24 bits of the sample are sent MSB first, unchanged in two's-complement form, in consecutive slots.
- R4: sdata_o changes only on the system clock edge that samples a bit-clock falling edge (bclk_i 1 then 0), or on a change of pwrdn_i. It stays constant at all other times.
- R5: When the previous half-frame was exactly 16 slots long, only sample bits 23 down to 8 are sent, MSB first.
- R6: While pwrdn_i is 1, sdata_o is 0.
- R7: Slots after the last sent bit of a half-frame drive 0. With fmt_i = 1, slot 0 drives 0 unless the half-frame is 24 or fewer slots long. In that case slot 0 carries the last sent bit of the previous channel (bit 0 for 24-bit frames, bit 8 for 16-bit frames), because that bit did not fit in its own half-frame.
- R8: A pair written with load_i is used from the next left half-frame on, for both channels. A load during a frame does not change the right channel of that frame.
- R9: After reset or after pwrdn_i falls, sdata_o stays 0 until the first left half-frame begins.
- R10: After reset, sdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, several times faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that writes left_i/right_i into the holding pair |
| left_i | input | SAMPLE_W | Left-channel sample, two's complement |
| right_i | input | SAMPLE_W | Right-channel sample, two's complement |
| bclk_i | input | 1 | Bit clock; data advances on its falling edge |
| wclk_i | input | 1 | Word-select clock; changes on a bit-clock falling edge |
| fmt_i | input | 1 | 0: MSB-justified, 1: I2S-style |
| pwrdn_i | input | 1 | 1 forces the output low and resets the framing |
| sdata_o | output | 1 | Serial data output |

## Verification
The bench deserializes every half-frame in both formats at 64, 48 and 32 bit clocks per frame. It compares each received word against one built from the applied samples, so a design with swapped channel polarity or a missing one-slot MSB delay produces the wrong words. The 48- and 32-clock I2S cases target the last bit that spills into slot 0 of the next half-frame; a design that dropped it or sent a stale bit fails there. The 32-clock cases catch a design that sends 24 bits where only 16 fit. Loads made mid-frame, extreme sample values, and a power-down cycle that resumes on a right half-frame check the capture instant, the zero tail and the quiet start-up.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SEEK  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } tx_state_e;
endpackage

// File: rtl/sertx_edge.sv
// Oversamples the bit clock and flags falling edges and word-clock changes.
module sertx_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_i,
    input  logic wclk_i,
    output logic fall_o,
    output logic word_edge_o
);
    logic bclk_prev;
    logic wclk_last;

    assign fall_o      = bclk_prev & ~bclk_i;
    assign word_edge_o = fall_o & (wclk_i != wclk_last);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bclk_prev <= 1'b0;
            wclk_last <= 1'b0;
        end else begin
            bclk_prev <= bclk_i;
            if (fall_o) begin
                wclk_last <= wclk_i;
            end
        end
    end
endmodule

// File: rtl/sertx_fsm.sv
// Framing controller: channel state, slot counter and frame-width detection.
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter  int SAMPLE_W    = 24,
    parameter  int NARROW_W    = 16,
    parameter  int NARROW_HALF = 16,
    parameter  int MAX_HALF    = 64,
    localparam int CNT_W       = $clog2(MAX_HALF + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fall_i,
    input  logic             word_edge_i,
    input  logic             wclk_i,
    input  logic             fmt_i,
    input  logic             pwrdn_i,
    output tx_state_e        state_o,
    output logic [CNT_W-1:0] slot_o,
    output logic             narrow_o,
    output logic             lead_left_o,
    output logic             chan_left_o,
    output logic             emit_o,
    output logic             tail_en_o,
    output logic             update_o
);
    localparam logic [CNT_W-1:0] SAT     = CNT_W'(MAX_HALF);
    localparam logic [CNT_W-1:0] NH_LAST = CNT_W'(NARROW_HALF - 1);
    localparam logic [CNT_W-1:0] WIN_W   = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] WIN_N   = CNT_W'(NARROW_W);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic             narrow_q, narrow_d;
    logic             left_lvl;

    assign left_lvl = fmt_i ? ~wclk_i : wclk_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (pwrdn_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_SEEK;
                ST_SEEK:  if (word_edge_i && left_lvl) state_d = ST_LEFT;
                ST_LEFT,
                ST_RIGHT: if (word_edge_i) state_d = left_lvl ? ST_LEFT : ST_RIGHT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    // slot counter and width detection
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q    <= '0;
            narrow_q <= 1'b0;
        end else if (pwrdn_i) begin
            idx_q    <= '0;
            narrow_q <= 1'b0;
        end else if (fall_i) begin
            if (word_edge_i) begin
                idx_q    <= '0;
                narrow_q <= narrow_d;
            end else if (idx_q != SAT) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        narrow_d    = word_edge_i ? (idx_q == NH_LAST) : narrow_q;
        narrow_o    = narrow_d;
        slot_o      = word_edge_i ? '0 : ((idx_q == SAT) ? idx_q : idx_q + 1'b1);
        update_o    = fall_i & ~pwrdn_i;
        chan_left_o = (state_d == ST_LEFT);
        emit_o      = (state_d == ST_LEFT) || (state_d == ST_RIGHT);
        lead_left_o = word_edge_i & left_lvl & (state_d == ST_LEFT);
        tail_en_o   = word_edge_i & fmt_i & (idx_q < (narrow_d ? WIN_N : WIN_W));
        state_o     = state_q;
    end
endmodule

// File: rtl/sertx_bitsel.sv
// Picks the bit for one slot from the sample word and the framing options.
module sertx_bitsel #(
    parameter int SAMPLE_W = 24,
    parameter int NARROW_W = 16,
    parameter int CNT_W    = 7
) (
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic [CNT_W-1:0]    slot_i,
    input  logic                fmt_i,
    input  logic                narrow_i,
    input  logic                tail_en_i,
    input  logic                tail_bit_i,
    output logic                bit_o
);
    logic [CNT_W-1:0]    pos;
    logic [CNT_W-1:0]    win;
    logic [SAMPLE_W-1:0] sh;

    always_comb begin
        win = narrow_i ? CNT_W'(NARROW_W) : CNT_W'(SAMPLE_W);
        pos = slot_i - CNT_W'(fmt_i);
        sh  = word_i << pos;
        if (fmt_i && (slot_i == '0)) begin
            bit_o = tail_en_i & tail_bit_i;
        end else if (pos < win) begin
            bit_o = sh[SAMPLE_W-1];
        end else begin
            bit_o = 1'b0;
        end
    end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import sertx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int NARROW_W    = 16,
    parameter int NARROW_HALF = 16,
    parameter int MAX_HALF    = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                bclk_i,
    input  logic                wclk_i,
    input  logic                fmt_i,
    input  logic                pwrdn_i,
    output logic                sdata_o
);
    localparam int CNT_W   = $clog2(MAX_HALF + 1);
    localparam int TAIL_LO = SAMPLE_W - NARROW_W;

    logic                fall, word_edge;
    tx_state_e           fsm_state;
    logic [CNT_W-1:0]    slot;
    logic                narrow, lead_left, chan_left, emit, tail_en, update;
    logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r;
    logic [SAMPLE_W-1:0] word_sel, prev_word;
    logic                tail_bit, next_bit, sd_q;

    sertx_edge u_edge (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bclk_i      (bclk_i),
        .wclk_i      (wclk_i),
        .fall_o      (fall),
        .word_edge_o (word_edge)
    );

    sertx_fsm #(
        .SAMPLE_W    (SAMPLE_W),
        .NARROW_W    (NARROW_W),
        .NARROW_HALF (NARROW_HALF),
        .MAX_HALF    (MAX_HALF)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fall_i      (fall),
        .word_edge_i (word_edge),
        .wclk_i      (wclk_i),
        .fmt_i       (fmt_i),
        .pwrdn_i     (pwrdn_i),
        .state_o     (fsm_state),
        .slot_o      (slot),
        .narrow_o    (narrow),
        .lead_left_o (lead_left),
        .chan_left_o (chan_left),
        .emit_o      (emit),
        .tail_en_o   (tail_en),
        .update_o    (update)
    );

    always_comb begin
        word_sel  = chan_left ? (lead_left ? hold_l : act_l) : act_r;
        prev_word = chan_left ? act_r : act_l;
        tail_bit  = narrow ? prev_word[TAIL_LO] : prev_word[0];
    end

    sertx_bitsel #(
        .SAMPLE_W (SAMPLE_W),
        .NARROW_W (NARROW_W),
        .CNT_W    (CNT_W)
    ) u_bitsel (
        .word_i     (word_sel),
        .slot_i     (slot),
        .fmt_i      (fmt_i),
        .narrow_i   (narrow),
        .tail_en_i  (tail_en),
        .tail_bit_i (tail_bit),
        .bit_o      (next_bit)
    );

    // holding pair written from the parallel port
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (load_i) begin
            hold_l <= left_i;
            hold_r <= right_i;
        end
    end

    // active pair and output bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_l <= '0;
            act_r <= '0;
            sd_q  <= 1'b0;
        end else if (pwrdn_i) begin
            act_l <= '0;
            act_r <= '0;
            sd_q  <= 1'b0;
        end else if (update) begin
            if (lead_left) begin
                act_l <= hold_l;
                act_r <= hold_r;
            end
            sd_q <= emit ? next_bit : 1'b0;
        end
    end

    assign sdata_o = sd_q & ~pwrdn_i;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                bclk_i,
    input logic                pwrdn_i,
    input logic                sdata_o,
    input tx_state_e           state_i,
    input logic [SAMPLE_W-1:0] act_l_i,
    input logic [SAMPLE_W-1:0] act_r_i
);
    AST_PWRDN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwrdn_i |-> !sdata_o);  // R6

    AST_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwrdn_i && !$past(pwrdn_i) && !($past(bclk_i, 2) && !$past(bclk_i)))
        |-> $stable(sdata_o));  // R4

    AST_QUIET_SEEK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_SEEK || state_i == ST_OFF) |-> !sdata_o);  // R9

    AST_LEFT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(act_l_i) |-> (state_i == ST_LEFT || state_i == ST_OFF));  // R8

    AST_RIGHT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(act_r_i) |-> (state_i == ST_LEFT || state_i == ST_OFF));  // R8
endmodule

bind serial_audio_tx sertx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .pwrdn_i (pwrdn_i),
    .sdata_o (sdata_o),
    .state_i (fsm_state),
    .act_l_i (act_l),
    .act_r_i (act_r)
);

// File: tb/serial_audio_tx_test.sv
module serial_audio_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [23:0] left_s = '0;
    logic [23:0] right_s = '0;
    logic        bclk = 1'b1;
    logic        wclk = 1'b0;
    logic        fmt = 1'b0;
    logic        pwrdn = 1'b0;
    logic        sdata;

    int n_run  = 0;
    int n_fail = 0;
    int stab_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_audio_tx uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .load_i  (load),
        .left_i  (left_s),
        .right_i (right_s),
        .bclk_i  (bclk),
        .wclk_i  (wclk),
        .fmt_i   (fmt),
        .pwrdn_i (pwrdn),
        .sdata_o (sdata)
    );

    typedef struct packed {
        logic       fmt;
        logic [5:0] half;
        logic       left_lvl;
    } vec_t;

    // format, slots per half-frame, word clock level of the left half (R1/R2)
    localparam vec_t VECS [6] = '{
        '{fmt: 1'b0, half: 6'd32, left_lvl: 1'b1},
        '{fmt: 1'b1, half: 6'd32, left_lvl: 1'b0},
        '{fmt: 1'b0, half: 6'd24, left_lvl: 1'b1},
        '{fmt: 1'b1, half: 6'd24, left_lvl: 1'b0},
        '{fmt: 1'b0, half: 6'd16, left_lvl: 1'b1},
        '{fmt: 1'b1, half: 6'd16, left_lvl: 1'b0}
    };

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [23:0] gen(input int n);
        if (n % 5 == 1) return 24'h800000;
        if (n % 5 == 2) return 24'h7FFFFF;
        return 24'((n * 32'h0003A5C7) ^ (n << 13) ^ 32'h00A50F);
    endfunction

    // expected half-frame, slot 0 in bit 31
    function automatic logic [31:0] exp_half(input logic [23:0] w, input logic [23:0] prevw,
                                             input logic f, input int hl);
        int wid;
        logic [31:0] e;
        wid = (hl == 16) ? 16 : 24;
        e = '0;
        for (int s = 0; s < hl; s++) begin
            if (f && s == 0) begin
                e[31] = (hl <= wid) ? prevw[24 - wid] : 1'b0;
            end else begin
                int p;
                p = s - int'(f);
                if (p < wid) e[31 - s] = w[23 - p];
            end
        end
        return e;
    endfunction

    function automatic string tags(input logic f, input int hl);
        string s;
        s = f ? "R2" : "R1";
        s = {s, (hl == 16) ? " R5" : " R3"};
        if (f && hl <= 24) s = {s, " R7 tail"};
        else s = {s, " R7 zero fill"};
        return {s, " R8"};
    endfunction

    // one bit period; called at a negedge of clk
    task automatic do_slot(input logic wlev, output logic b);
        bclk = 1'b0;
        wclk = wlev;
        repeat (4) @(negedge clk);
        b = sdata;
        bclk = 1'b1;
        repeat (3) @(negedge clk);
        if (sdata !== b) stab_err++;
        @(negedge clk);
    endtask

    task automatic do_half(input logic wlev, input int hl, input logic do_load,
                           input logic [23:0] nl, input logic [23:0] nr,
                           output logic [31:0] got);
        got = '0;
        for (int s = 0; s < hl; s++) begin
            logic b;
            do_slot(wlev, b);
            got[31 - s] = b;
            if (s == 0 && do_load) begin
                left_s  = nl;
                right_s = nr;
                load    = 1'b1;
                @(negedge clk);
                load    = 1'b0;
            end
        end
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] m_hl, m_hr, m_al, m_ar, prev_r;
        logic [31:0] got, expv;
        int n;
        n = 10;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check32("R10 output low after reset", {31'b0, sdata}, 32'h0);

        m_hl = gen(n); m_hr = gen(n + 1); n += 2;
        left_s = m_hl; right_s = m_hr; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_al = '0; m_ar = '0;

        for (int v = 0; v < 6; v++) begin
            int hl;
            fmt = VECS[v].fmt;
            hl  = int'(VECS[v].half);
            for (int fr = 0; fr < 4; fr++) begin
                logic [23:0] nl, nr;
                prev_r = m_ar;
                m_al = m_hl; m_ar = m_hr;
                expv = exp_half(m_al, prev_r, fmt, hl);
                do_half(VECS[v].left_lvl, hl, 1'b0, '0, '0, got);
                if (fr >= 2) check32({tags(fmt, hl), " left"}, got, expv);
                nl = gen(n); nr = gen(n + 1); n += 2;
                expv = exp_half(m_ar, m_al, fmt, hl);
                do_half(~VECS[v].left_lvl, hl, 1'b1, nl, nr, got);
                if (fr >= 2) check32({tags(fmt, hl), " right"}, got, expv);
                m_hl = nl; m_hr = nr;
            end
        end

        // power-down with live samples: output held low (R6)
        fmt = 1'b0;
        pwrdn = 1'b1;
        do_half(1'b1, 32, 1'b0, '0, '0, got);
        check32("R6 left half during power-down", got, 32'h0);
        do_half(1'b0, 32, 1'b1, 24'h5A5A5A, 24'hC3C3C3, got);
        check32("R6 right half during power-down", got, 32'h0);
        m_hl = 24'h5A5A5A; m_hr = 24'hC3C3C3;
        pwrdn = 1'b0;
        @(negedge clk);

        // resume on a right half: stays quiet until a left half (R9)
        do_half(1'b0, 32, 1'b0, '0, '0, got);
        check32("R9 right half before first left half", got, 32'h0);
        do_half(1'b1, 32, 1'b0, '0, '0, got);
        check32("R9 R8 first left half after power-down", got, exp_half(m_hl, 24'h0, 1'b0, 32));
        do_half(1'b0, 32, 1'b1, 24'h000001, 24'hFFFFFF, got);
        check32("R8 right half ignores mid-frame load", got, exp_half(m_hr, m_hl, 1'b0, 32));
        do_half(1'b1, 32, 1'b0, '0, '0, got);
        check32("R8 R3 next left half uses new pair", got, exp_half(24'h000001, m_hr, 1'b0, 32));
        do_half(1'b0, 32, 1'b0, '0, '0, got);
        check32("R8 R3 next right half uses new pair", got, exp_half(24'hFFFFFF, 24'h000001, 1'b0, 32));

        check32("R4 data stable while bit clock high", 32'(stab_err), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule